// File: doc/BRIEF.md
# Environment Configuration Register Unit

This block holds the machine-level and supervisor-level environment configuration registers of a processor hart. Software reaches them through a single-cycle CSR port: the address and write data are presented with a write enable, and the new value is stored at the next rising clock edge. Read data is combinational from the address. Every write is filtered field by field, so only the features that the hart's configuration straps allow can ever be set.

Two bits are stored. The timer-compare enable is exported to the timer logic. The fence-widening bit, which makes I/O fences also order memory, is held in both registers. The unit combines the two copies with the current privilege level into a single qualifier for the fence logic.

On 32-bit harts the 64-bit machine register is split across two addresses. Writing one half leaves the other half as it was. The supervisor register is always one machine word wide.

Top module: `envcfg_csr`

## Requirements
- R1: After reset both registers read as zero, the timer-compare enable output is 0 and the fence qualifier is 0.
- R2: The machine register (0x30A) exists only when user mode is strapped on. Its upper half (0x31A) exists only when user mode is on and XLEN is 32. The supervisor register (0x10A) exists only when supervisor mode is on. Reading any other address, or an address that is not present under the current straps, asserts the illegal flag and returns zero.
- R3: The fence-widening bit sits at bit 0 of both registers. It takes the written value only when the fence-writable strap is 1, and is otherwise stored as 0.
- R4: The timer-compare enable sits at bit 63 of the machine register. It takes the written value only when the timer-compare strap is 1, and is otherwise stored as 0. The exported enable output follows the stored bit.
- R5: Every other bit of both registers reads as zero, whatever value is written.
- R6: With XLEN 32, a write to 0x30A replaces bits 31:0 and keeps bits 63:32, and a write to 0x31A replaces bits 63:32 and keeps bits 31:0. Legalization is applied to the merged 64-bit value.
- R7: The fence qualifier is 0 in machine mode (privilege code 3). In supervisor mode (code 1) it equals the machine fence bit. In user mode (code 0) it is the OR of the machine and supervisor fence bits.
- R8: A write to an address that is illegal under the current straps changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data |
| csr_we | input | 1 | Write enable |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| cfg_has_smode | input | 1 | Supervisor mode present |
| cfg_has_umode | input | 1 | User mode present |
| cfg_has_tcmp | input | 1 | Timer-compare feature present |
| cfg_fiom_wr | input | 1 | Fence-widening bit writable |
| csr_rdata | output | XLEN | Read data |
| csr_illegal | output | 1 | Address not present under current straps |
| stce_o | output | 1 | Timer-compare enable |
| fiom_active | output | 1 | I/O fence also orders memory |

## Verification
All-ones writes are made under each strap combination. Each such write sets every writable bit at once, so a field leaking through its legalization shows up as an unexpected read bit. On a 32-bit instance the two machine halves are written in both orders, then one is written back to zero. This separates a correct merge from a write that overwrites or clears the other half. The two fence bits are set one at a time and each privilege code is applied, which shows which copy feeds each mode. Writes are also made while user mode is strapped off and then read back after the strap is turned on, which shows that no hidden state was changed.

// File: rtl/envcfg_csr.sv
module envcfg_csr #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            csr_we,
  input  logic [1:0]      priv,
  input  logic            cfg_has_smode,
  input  logic            cfg_has_umode,
  input  logic            cfg_has_tcmp,
  input  logic            cfg_fiom_wr,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  output logic            stce_o,
  output logic            fiom_active
);

  localparam logic [11:0] A_MCFG  = 12'h30A;
  localparam logic [11:0] A_MCFGH = 12'h31A;
  localparam logic [11:0] A_SCFG  = 12'h10A;
  localparam bit          SPLIT   = (XLEN == 32);
  localparam logic [1:0]  PRV_U   = 2'd0;
  localparam logic [1:0]  PRV_S   = 2'd1;
  localparam logic [1:0]  PRV_M   = 2'd3;

  logic m_fiom, m_stce, s_fiom;
  logic [63:0] mval, merged;
  logic hit_m, hit_mh, hit_s;

  assign hit_m  = (csr_addr == A_MCFG)  && cfg_has_umode;
  assign hit_mh = (csr_addr == A_MCFGH) && cfg_has_umode && SPLIT;
  assign hit_s  = (csr_addr == A_SCFG)  && cfg_has_smode;
  assign csr_illegal = !(hit_m || hit_mh || hit_s);

  assign mval = {m_stce, 62'b0, m_fiom};

  always_comb begin
    csr_rdata = '0;
    if (hit_m)       csr_rdata = mval[XLEN-1:0];
    else if (hit_mh) csr_rdata = mval[63 -: XLEN];
    else if (hit_s)  csr_rdata = {{(XLEN-1){1'b0}}, s_fiom};
  end

  always_comb begin
    merged = mval;
    if (hit_m)       merged[XLEN-1:0] = csr_wdata;
    else if (hit_mh) merged[63:32]    = csr_wdata[31:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_fiom <= 1'b0;
      m_stce <= 1'b0;
      s_fiom <= 1'b0;
    end else if (csr_we) begin
      if (hit_m || hit_mh) begin
        m_fiom <= cfg_fiom_wr  & merged[0];
        m_stce <= cfg_has_tcmp & merged[63];
      end
      if (hit_s) s_fiom <= cfg_fiom_wr & csr_wdata[0];
    end
  end

  assign stce_o = m_stce;

  always_comb begin
    case (priv)
      PRV_S:   fiom_active = m_fiom;
      PRV_U:   fiom_active = m_fiom | s_fiom;
      default: fiom_active = 1'b0;
    endcase
  end

  p_illegal_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_rdata == '0));

  p_fiom_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !cfg_fiom_wr && !csr_illegal && csr_addr != A_MCFGH) |=> !fiom_active || priv == PRV_U && s_fiom ^ m_fiom);

  p_stce_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !cfg_has_tcmp && (hit_m || hit_mh)) |=> !stce_o);

  p_hi_keeps_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && hit_mh && cfg_fiom_wr) |=> (m_fiom == $past(m_fiom)));

  p_mmode_no_fiom_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == PRV_M) |-> !fiom_active);

  p_undef_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_illegal) |=> (m_fiom == $past(m_fiom) && m_stce == $past(m_stce) && s_fiom == $past(s_fiom)));

endmodule

// File: tb/tb_envcfg_csr.sv
module tb_envcfg_csr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic we = 1'b0;
  logic [1:0] priv = 2'd0;
  logic smode = 1'b1, umode = 1'b1, tcmp = 1'b1, fwr = 1'b1;
  logic [63:0] rd64;
  logic [31:0] rd32;
  logic ill64, ill32, stce64, stce32, fa64, fa32;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  envcfg_csr #(.XLEN(64)) dut (
    .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_wdata(wdata), .csr_we(we),
    .priv(priv), .cfg_has_smode(smode), .cfg_has_umode(umode),
    .cfg_has_tcmp(tcmp), .cfg_fiom_wr(fwr),
    .csr_rdata(rd64), .csr_illegal(ill64), .stce_o(stce64), .fiom_active(fa64));

  envcfg_csr #(.XLEN(32)) dut32 (
    .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_wdata(wdata[31:0]), .csr_we(we),
    .priv(priv), .cfg_has_smode(smode), .cfg_has_umode(umode),
    .cfg_has_tcmp(tcmp), .cfg_fiom_wr(fwr),
    .csr_rdata(rd32), .csr_illegal(ill32), .stce_o(stce32), .fiom_active(fa32));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic s, logic u, logic t, logic f);
    @(negedge clk);
    smode = s; umode = u; tcmp = t; fwr = f; we = 1'b0; priv = 2'd0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a);
    @(negedge clk);
    addr = a;
    #1;
  endtask

  task automatic t_reset;
    do_reset(1, 1, 1, 1);
    rd(12'h30A); check("R1 m64", rd64, 0); check("R1 m32", {32'b0, rd32}, 0);
    rd(12'h10A); check("R1 s64", rd64, 0);
    check("R1 stce", {stce64, stce32}, 0);
    check("R1 fiom", {fa64, fa32}, 0);
  endtask

  task automatic t_all_on;
    do_reset(1, 1, 1, 1);
    wr(12'h30A, '1);
    rd(12'h30A); check("R3 R4 R5 m64", rd64, 64'h8000_0000_0000_0001);
    check("R4 stce out", {63'b0, stce64}, 1);
    wr(12'h10A, '1);
    rd(12'h10A); check("R5 s64", rd64, 1); check("R5 s32", {32'b0, rd32}, 1);
  endtask

  task automatic t_fiom_locked;
    do_reset(1, 1, 1, 0);
    wr(12'h30A, '1); wr(12'h10A, '1);
    rd(12'h30A); check("R3 m locked", rd64, 64'h8000_0000_0000_0000);
    rd(12'h10A); check("R3 s locked", rd64, 0);
    priv = 2'd0; #1; check("R3 fiom off", {63'b0, fa64}, 0);
  endtask

  task automatic t_stce_locked;
    do_reset(1, 1, 0, 1);
    wr(12'h30A, '1);
    rd(12'h30A); check("R4 stce locked", rd64, 1);
    check("R4 stce out", {63'b0, stce64}, 0);
    wr(12'h31A, '1);
    rd(12'h31A); check("R4 hi locked", {32'b0, rd32}, 0);
  endtask

  task automatic t_split;
    do_reset(1, 1, 1, 1);
    wr(12'h31A, 64'hFFFF_FFFF);
    rd(12'h31A); check("R6 hi", {32'b0, rd32}, 32'h8000_0000);
    rd(12'h30A); check("R6 lo untouched", {32'b0, rd32}, 0);
    wr(12'h30A, 64'hFFFF_FFFF);
    rd(12'h30A); check("R6 lo", {32'b0, rd32}, 1);
    rd(12'h31A); check("R6 hi kept", {32'b0, rd32}, 32'h8000_0000);
    wr(12'h31A, 64'h0);
    rd(12'h30A); check("R6 lo kept", {32'b0, rd32}, 1);
    check("R6 stce cleared", {63'b0, stce32}, 0);
  endtask

  task automatic t_presence;
    do_reset(1, 1, 1, 1);
    rd(12'h31A); check("R2 hi absent rv64", {63'b0, ill64}, 1);
    check("R2 hi present rv32", {63'b0, ill32}, 0);
    rd(12'h7C0); check("R2 other addr", {62'b0, ill64, ill32}, 2'b11);
    do_reset(0, 0, 1, 1);
    wr(12'h30A, '1); wr(12'h10A, '1);
    rd(12'h30A); check("R2 m absent", {62'b0, ill64, ill32}, 2'b11);
    check("R2 zero", rd64, 0);
    rd(12'h10A); check("R2 s absent", {63'b0, ill64}, 1);
    @(negedge clk); smode = 1'b1; umode = 1'b1;
    rd(12'h30A); check("R8 m untouched", rd64, 0);
    rd(12'h10A); check("R8 s untouched", rd64, 0);
  endtask

  task automatic t_priv;
    do_reset(1, 1, 1, 1);
    wr(12'h30A, 64'h1);
    priv = 2'd0; #1; check("R7 U m", {63'b0, fa64}, 1);
    priv = 2'd1; #1; check("R7 S m", {63'b0, fa64}, 1);
    priv = 2'd3; #1; check("R7 M", {63'b0, fa64}, 0);
    wr(12'h30A, 64'h0); wr(12'h10A, 64'h1);
    priv = 2'd0; #1; check("R7 U s", {63'b0, fa64}, 1);
    priv = 2'd1; #1; check("R7 S s", {63'b0, fa64}, 0);
    priv = 2'd3; #1; check("R7 M s", {63'b0, fa32}, 0);
  endtask

  initial begin
    t_reset();
    t_all_on();
    t_fiom_locked();
    t_stce_locked();
    t_split();
    t_presence();
    t_priv();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule